// File: doc/BRIEF.md
# Clock Control Status Register

This block is a single 32-bit control and status register inside a clock controller. Software uses it to turn on a main PLL and two auxiliary PLLs. It reads back each PLL's lock state as a read-only ready flag. It also keeps a set of oscillator control and range fields as plain storage. Writes come over a simple bus write port with per-byte enables and take effect on the next clock edge with no wait states. Reads return the current register contents as a combinational value.

Hardware takes part in the enable bits in two ways. When a low-power mode is entered, all three PLL enables are forced off. While the main PLL is the system clock source, software cannot switch it off. One storage bit, the external clock bypass select, is left untouched by reset so that a bypass setup survives a warm reset.

Top module: `clkctl_csr`

## Requirements
- R1: After reset the register reads 0x0000_0063, leaving aside bit 18.
- R2: Bit 18 (bypass select) can be written, and an assertion of reset does not change its value.
- R3: Byte enable `wr_be[k]` gates writes to bits 8k+7:8k. A write is visible in the readback one clock edge after it is presented.
- R4: Bits 29, 27 and 25 are ready flags for auxiliary PLL 2, auxiliary PLL 1 and the main PLL. They are driven by `pll_lock[2]`, `pll_lock[1]` and `pll_lock[0]` through a two-flop synchronizer, so a lock change shows on the second clock edge after it. Writes to these bits are ignored.
- R5: Bits 28, 26 and 24 are read/write enables for auxiliary PLL 2, auxiliary PLL 1 and the main PLL. They drive `pll_en[2]`, `pll_en[1]` and `pll_en[0]`.
- R6: A cycle with `lp_entry` high clears all three enables on the next edge. This clear takes priority over a write in the same cycle.
- R7: While `sysclk_sel` equals 2'b11 (main PLL is the system clock), a write of 0 to bit 24 is ignored. Writes of 1 to bit 24 and writes to the other bits still apply.
- R8: Bits 31:30, 23:20 and 15:12 always read 0, and writes to them have no effect.
- R9: Bits 19:16 and 11:0 are plain read/write storage with no hardware side effects.
- R10: Only a write whose `wr_addr` equals the register offset (0x00) changes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| pll_lock | input | 3 | Lock inputs: [0] main, [1] aux 1, [2] aux 2 |
| lp_entry | input | 1 | One-cycle strobe for entry to a low-power mode |
| sysclk_sel | input | 2 | System clock source select; 2'b11 means main PLL |
| rd_data | output | 32 | Register readback |
| pll_en | output | 3 | PLL enable lines: [0] main, [1] aux 1, [2] aux 2 |

## Verification
The bench checks that the bypass bit survives a reset pulse. A design that reset it would read 0x0000_0063 instead of 0x0004_0063. It writes 0 to the main enable while the main PLL is the system clock, where a design without the guard would drop the system clock. It also presents a low-power strobe together with a write of ones: the enables must stay 0, and a design that lets the write win would leave PLLs running. Further checks cover partial-byte writes into reserved nibbles, writes to the ready flags, and the exact two-edge delay of the lock synchronizer. These would expose leaking reserved bits, writable flags, and a synchronizer that is one stage short or one stage long.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned BE_W        = REG_W / 8;
  localparam int unsigned NUM_PLL     = 3;
  localparam int unsigned EN_BASE     = 24;   // enables at 24,26,28
  localparam int unsigned RDY_BASE    = 25;   // ready flags at 25,27,29
  localparam int unsigned BYP_BIT     = 18;
  localparam logic [REG_W-1:0] RST_VAL    = 32'h0000_0063;
  localparam logic [REG_W-1:0] STORE_MASK = 32'h000F_0FFF;

  function automatic int unsigned en_pos(input int unsigned idx);
    return EN_BASE + 2 * idx;
  endfunction

  function automatic int unsigned rdy_pos(input int unsigned idx);
    return RDY_BASE + 2 * idx;
  endfunction

  function automatic logic [REG_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
    logic [REG_W-1:0] m;
    for (int unsigned k = 0; k < BE_W; k++) begin
      m[8*k +: 8] = {8{be[k]}};
    end
    return m;
  endfunction
endpackage

// File: rtl/clkctl_lock_sync.sv
module clkctl_lock_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lock_i,
  output logic [WIDTH-1:0] lock_o
);
  localparam int unsigned AGE_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = lock_i;
    for (int unsigned s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int unsigned s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign lock_o = stg_q[STAGES-1];

  // cycles since reset, saturating; guards the latency check
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      age_q <= '0;
    else if (age_q != AGE_W'(STAGES)) age_q <= age_q + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      assert_ready_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_W'(STAGES)) |-> (lock_o == $past(lock_i, 2)))
        else $error("ready flag latency mismatch");
    end
  endgenerate
endmodule

// File: rtl/clkctl_pll_enables.sv
module clkctl_pll_enables #(
  parameter int unsigned NUM      = 3,
  parameter int unsigned MAIN_IDX = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hit,     // write to this register with top byte enabled
  input  logic [NUM-1:0] wr_bits,
  input  logic           lp_entry,
  input  logic           main_is_sys,
  output logic [NUM-1:0] en_o
);
  logic [NUM-1:0] en_q;
  logic [NUM-1:0] en_d;

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_en
      always_comb begin
        en_d[i] = en_q[i];
        if (lp_entry) begin
          en_d[i] = 1'b0;
        end else if (wr_hit) begin
          if ((i == MAIN_IDX) && main_is_sys && !wr_bits[i]) en_d[i] = en_q[i];
          else                                                en_d[i] = wr_bits[i];
        end
      end

      if (i != MAIN_IDX) begin : g_aux_chk
        assert_aux_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_hit && !lp_entry) |=> (en_o[i] == $past(wr_bits[i])))
          else $error("aux enable write lost");
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  assert_lp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_entry |=> (en_o == '0))
    else $error("enables survived low-power entry");

  assert_main_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o[MAIN_IDX] && main_is_sys && !lp_entry) |=> en_o[MAIN_IDX])
    else $error("main enable cleared while system clock");
endmodule

// File: rtl/clkctl_store.sv
module clkctl_store
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_mask,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] BYP_MASK = REG_W'(1) << BYP_BIT;
  localparam logic [REG_W-1:0] RST_MASK = STORE_MASK & ~BYP_MASK;

  logic [REG_W-1:0] q_q, q_d, sel;
  logic             byp_q, byp_d;

  always_comb begin
    sel   = wr_hit ? (wr_mask & RST_MASK) : '0;
    q_d   = (q_q & ~sel) | (wr_data & sel);
    byp_d = (wr_hit && wr_mask[BYP_BIT]) ? wr_data[BYP_BIT] : byp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL & RST_MASK;
    else        q_q <= q_d;
  end

  // bypass select is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    byp_q <= byp_d;
  end

  always_comb begin
    q_o          = q_q;
    q_o[BYP_BIT] = byp_q;
  end

  assert_store_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q_q))
    else $error("storage changed without a write");
endmodule

// File: rtl/clkctl_csr.sv
module clkctl_csr
  import clkctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter logic [7:0]  REG_OFFSET   = 8'h00,
  parameter int unsigned SEL_W        = 2,
  parameter logic [1:0]  SEL_MAIN_PLL = 2'b11,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [NUM_PLL-1:0] pll_lock,
  input  logic               lp_entry,
  input  logic [SEL_W-1:0]   sysclk_sel,
  output logic [REG_W-1:0]   rd_data,
  output logic [NUM_PLL-1:0] pll_en
);
  localparam int unsigned MAIN_IDX = 0;
  localparam int unsigned TOP_BYTE = BE_W - 1;

  logic               hit;
  logic [REG_W-1:0]   wmask;
  logic [NUM_PLL-1:0] en_wbits;
  logic [NUM_PLL-1:0] rdy;
  logic [REG_W-1:0]   store_q;

  assign hit   = wr_en && (wr_addr == ADDR_W'(REG_OFFSET));
  assign wmask = be_to_mask(wr_be);

  generate
    for (genvar i = 0; i < NUM_PLL; i++) begin : g_wbits
      assign en_wbits[i] = wr_data[en_pos(i)];
    end
  endgenerate

  clkctl_lock_sync #(.WIDTH(NUM_PLL), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock_i (pll_lock),
    .lock_o (rdy)
  );

  clkctl_pll_enables #(.NUM(NUM_PLL), .MAIN_IDX(MAIN_IDX)) u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (hit && wr_be[TOP_BYTE]),
    .wr_bits     (en_wbits),
    .lp_entry    (lp_entry),
    .main_is_sys (sysclk_sel == SEL_W'(SEL_MAIN_PLL)),
    .en_o        (pll_en)
  );

  clkctl_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (hit),
    .wr_mask (wmask),
    .wr_data (wr_data),
    .q_o     (store_q)
  );

  always_comb begin
    rd_data = store_q & STORE_MASK;
    for (int unsigned i = 0; i < NUM_PLL; i++) begin
      rd_data[en_pos(i)]  = pll_en[i];
      rd_data[rdy_pos(i)] = rdy[i];
    end
  end

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:30] == 2'b00) && (rd_data[23:20] == 4'h0) && (rd_data[15:12] == 4'h0))
    else $error("reserved bits read nonzero");

  assert_foreign_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit && !lp_entry) |=> $stable(pll_en))
    else $error("write to other offset changed enables");
endmodule

// File: tb/clkctl_csr_tb_top.sv
module clkctl_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [2:0]  pll_lock;
  logic        lp_entry;
  logic [1:0]  sysclk_sel;
  logic [31:0] rd_data;
  logic [2:0]  pll_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  clkctl_csr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .pll_lock(pll_lock), .lp_entry(lp_entry),
    .sysclk_sel(sysclk_sel), .rd_data(rd_data), .pll_en(pll_en)
  );

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] wd;
    logic [1:0]  sel;
    logic        lp;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'b0100, 32'h0000_0000, 2'd0, 1'b0, 32'h0000_0063}, // R3 clear byte 2
    '{4'b1111, 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h150F_0FFF}, // R5 R8 R9 all ones
    '{4'b0001, 32'h0000_0000, 2'd0, 1'b0, 32'h150F_0F00}, // R3 byte 0 only
    '{4'b0010, 32'h0000_5A00, 2'd0, 1'b0, 32'h150F_0A00}, // R8 reserved nibble
    '{4'b1000, 32'h0400_0000, 2'd0, 1'b0, 32'h040F_0A00}, // R5 mixed enables
    '{4'b1000, 32'h1500_0000, 2'd3, 1'b0, 32'h150F_0A00}, // R7 set while sys
    '{4'b1000, 32'h0000_0000, 2'd3, 1'b0, 32'h010F_0A00}, // R7 main held
    '{4'b0000, 32'h0000_0000, 2'd3, 1'b1, 32'h000F_0A00}, // R6 lp clears
    '{4'b1000, 32'h1500_0000, 2'd0, 1'b1, 32'h000F_0A00}, // R6 lp wins
    '{4'b1100, 32'h15F5_0000, 2'd0, 1'b0, 32'h1505_0A00}, // R8 R9 byte 2/3
    '{4'b1111, 32'h0000_0000, 2'd0, 1'b0, 32'h0000_0000}  // R5 R9 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                          input logic [1:0] sel, input logic lp);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; sysclk_sel = sel; lp_entry = lp;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; lp_entry = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
    pll_lock = '0; lp_entry = 1'b0; sysclk_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset value, bit 18 masked out
    check("R1", rd_data & ~32'h0004_0000, 32'h0000_0063);
    check("R5", {29'd0, pll_en}, 32'd0);

    // R2 bypass bit survives reset
    do_write(8'h00, 4'b0100, 32'h0004_0000, 2'd0, 1'b0);
    check("R2", rd_data, 32'h0004_0063);
    pulse_reset();
    check("R2", rd_data, 32'h0004_0063);

    for (int i = 0; i < NV; i++) begin
      do_write(8'h00, VECS[i].be, VECS[i].wd, VECS[i].sel, VECS[i].lp);
      check($sformatf("vector %0d", i), rd_data, VECS[i].exp);
    end

    // R5 enable outputs follow the register
    do_write(8'h00, 4'b1000, 32'h1400_0000, 2'd0, 1'b0);
    check("R5", {29'd0, pll_en}, 32'd6);
    do_write(8'h00, 4'b1000, 32'h0000_0000, 2'd0, 1'b0);

    // R10 write at another offset ignored
    do_write(8'h04, 4'b1111, 32'hFFFF_FFFF, 2'd0, 1'b0);
    check("R10", rd_data, 32'h0000_0000);

    // R4 two-edge synchronizer latency
    @(negedge clk); pll_lock = 3'b101;
    @(negedge clk);
    check("R4", rd_data, 32'h0000_0000);
    @(negedge clk);
    check("R4", rd_data, 32'h2200_0000);

    // R4 ready flags not writable
    do_write(8'h00, 4'b1000, 32'hFF00_0000, 2'd0, 1'b0);
    check("R4", rd_data, 32'h3700_0000);
    pll_lock = 3'b000;
    repeat (2) @(negedge clk);
    check("R4", rd_data, 32'h1500_0000);

    // R6 with main as system clock, lp still clears
    do_write(8'h00, 4'b0000, 32'h0, 2'd3, 1'b1);
    check("R6", {29'd0, pll_en}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule